// File: doc/BRIEF.md
# PCI Type-0 Configuration Target

This block is the target side of configuration accesses on a 32-bit PCI bus. It watches for the start of a bus transaction while its select line is high. It claims the cycle only for a Type-0 configuration read or write. It then runs the data phases against a 64-dword register file that covers the 256-byte configuration space.

A claimed cycle is answered with medium decode timing, so DEVSEL# and TRDY# go low together on the second clock after the address phase. Each completed data phase moves the internal dword pointer on by one. Reads always return a full dword. Writes change only the byte lanes that are enabled. Dword 0 holds the vendor and device IDs and dword 2 holds the revision and class code; both are fixed. A burst that reaches the last dword is ended with a disconnect-with-data. The AD bus is split into an input, an output and an output enable.

Top module: `pci_cfg_target`

## Requirements
- R1: A cycle is claimed only when, on the first clock with FRAME# low, IDSEL is high, AD[1:0] is 2'b00 and C/BE# is 4'hA (read) or 4'hB (write). In any other case DEVSEL# stays high for the whole cycle and the register file is not changed.
- R2: Medium decode: DEVSEL# is still high on the clock after the address phase. DEVSEL# and TRDY# both go low on the clock after that.
- R3: During read data phases, ad_oe is high and ad_out carries all 32 bits of the addressed dword, whatever C/BE# holds.
- R4: On a write data phase, byte lane i (AD[8i+7:8i]) of the addressed dword is updated only when C/BE#[i] is low.
- R5: A write data phase with C/BE# = 4'hF writes nothing, but the dword pointer still advances.
- R6: The starting dword comes from AD[7:2] in the address phase. The pointer advances only on clocks where IRDY# and TRDY# are both low; wait states with IRDY# high leave it unchanged.
- R7: Dword 0 always reads {DEVICE_ID, VENDOR_ID} and dword 2 always reads {CLASS_CODE, REVISION_ID}. Writes to them are discarded.
- R8: After a data transfer made with FRAME# high, DEVSEL#, TRDY# and ad_oe are all deasserted on the next clock.
- R9: In the data phase at dword 63, STOP# is low together with TRDY#. If that transfer is made with FRAME# still low, TRDY# goes high while STOP# and DEVSEL# stay low until FRAME# rises. The block then returns to idle.
- R10: After reset, DEVSEL#, TRDY# and STOP# are high, ad_oe is low and every writable dword reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | FRAME#, transaction framing from the master |
| irdy_n | input | 1 | IRDY#, initiator ready |
| idsel | input | 1 | Configuration select |
| cbe_n | input | 4 | C/BE#, command in the address phase, byte enables in data phases |
| ad_in | input | 32 | AD as seen on the bus |
| ad_out | output | 32 | AD value driven during read data phases |
| ad_oe | output | 1 | Output enable for ad_out |
| devsel_n | output | 1 | DEVSEL#, target claims the cycle |
| trdy_n | output | 1 | TRDY#, target ready |
| stop_n | output | 1 | STOP#, target requests termination |

## Verification
The bound checker watches the handshake on every clock. It checks that a falling DEVSEL# always follows a qualifying Type-0 address phase two clocks earlier. It also checks that TRDY# is never low without DEVSEL#, that AD is driven only while TRDY# is low, that the bus is released right after a final transfer, and that a disconnect holds STOP# while dropping TRDY#. Some behaviour only the directed scenarios can show, because the outputs alone do not reveal it on any given clock. This covers the byte-lane merging on writes and the fact that zero-enable phases still advance the pointer. It also covers wait states that must not advance the pointer, the fixed ID dwords, and ignored accesses that leave the register file untouched. These are checked by reading back through normal configuration reads.

// File: rtl/pci_cfg_target.sv
module pci_cfg_target #(
  parameter logic [15:0] VENDOR_ID   = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID   = 16'h3C4D,
  parameter logic [7:0]  REVISION_ID = 8'h01,
  parameter logic [23:0] CLASS_CODE  = 24'h078000,
  parameter int          DWORDS      = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n
);
  localparam int AW = $clog2(DWORDS);
  localparam logic [AW-1:0] LAST = AW'(DWORDS - 1);
  localparam logic [3:0] CMD_RD = 4'hA;
  localparam logic [3:0] CMD_WR = 4'hB;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DATA, S_STOP} st_t;

  st_t           st;
  logic          frame_q;
  logic          is_wr;
  logic [AW-1:0] ptr;
  logic [31:0]   regs [DWORDS];

  wire addr_phase = !frame_n && frame_q;
  wire claim = addr_phase && idsel && (ad_in[1:0] == 2'b00) &&
               ((cbe_n == CMD_RD) || (cbe_n == CMD_WR));
  wire xfer    = (st == S_DATA) && !irdy_n;
  wire at_last = (ptr == LAST);
  wire fixed   = (ptr == AW'(0)) || (ptr == AW'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      frame_q <= 1'b1;
      is_wr   <= 1'b0;
      ptr     <= '0;
    end else begin
      frame_q <= frame_n;
      case (st)
        S_IDLE: if (claim) begin
          st    <= S_WAIT;
          ptr   <= ad_in[AW+1:2];
          is_wr <= cbe_n[0];
        end
        S_WAIT: st <= S_DATA;
        S_DATA: if (xfer) begin
          ptr <= ptr + AW'(1);
          if (frame_n)      st <= S_IDLE;
          else if (at_last) st <= S_STOP;
        end
        S_STOP: if (frame_n) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DWORDS; i++) regs[i] <= '0;
    end else if (xfer && is_wr && !fixed) begin
      for (int b = 0; b < 4; b++)
        if (!cbe_n[b]) regs[ptr][8*b +: 8] <= ad_in[8*b +: 8];
    end
  end

  always_comb begin
    if (ptr == AW'(0))      ad_out = {DEVICE_ID, VENDOR_ID};
    else if (ptr == AW'(2)) ad_out = {CLASS_CODE, REVISION_ID};
    else                    ad_out = regs[ptr];
  end

  assign ad_oe    = (st == S_DATA) && !is_wr;
  assign devsel_n = !((st == S_DATA) || (st == S_STOP));
  assign trdy_n   = !(st == S_DATA);
  assign stop_n   = !(((st == S_DATA) && at_last) || (st == S_STOP));
endmodule

// File: rtl/pci_cfg_target_chk.sv
module pci_cfg_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_n,
  input logic        irdy_n,
  input logic        idsel,
  input logic [3:0]  cbe_n,
  input logic [31:0] ad_in,
  input logic        ad_oe,
  input logic        devsel_n,
  input logic        trdy_n,
  input logic        stop_n
);
  p_claim_type0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> ($past(idsel, 2) && $past(ad_in[1:0], 2) == 2'b00 &&
                         $past(cbe_n[3:1], 2) == 3'b101 && !$past(frame_n, 2)));

  p_medium_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> !trdy_n);

  p_trdy_needs_devsel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);

  p_drive_only_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !trdy_n);

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && !irdy_n && !trdy_n) |=> (devsel_n && trdy_n && !ad_oe));

  p_disconnect_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !trdy_n && !irdy_n && !frame_n) |=> (!stop_n && trdy_n && !devsel_n));

  p_stop_claimed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> !devsel_n);
endmodule

bind pci_cfg_target pci_cfg_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
  .cbe_n(cbe_n), .ad_in(ad_in), .ad_oe(ad_oe), .devsel_n(devsel_n),
  .trdy_n(trdy_n), .stop_n(stop_n)
);

// File: tb/tb_pci_cfg_target.sv
module tb_pci_cfg_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic        idsel = 1'b0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic        ad_oe, devsel_n, trdy_n, stop_n;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pci_cfg_target dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Address phase plus decode wait; returns at the falling edge where data phases start.
  task automatic start(input logic [3:0] cmd, input logic [7:0] byte_addr);
    @(negedge clk);
    frame_n = 1'b0; idsel = 1'b1; cbe_n = cmd; ad_in = {24'h0, byte_addr};
    @(negedge clk);
    idsel = 1'b0; irdy_n = 1'b1; cbe_n = 4'h0; ad_in = '0;
    chk(devsel_n === 1'b1, "R2 no claim on first clock", {31'h0, devsel_n}, 32'h1);
    @(negedge clk);
    chk(devsel_n === 1'b0 && trdy_n === 1'b0, "R2 devsel+trdy on second clock",
        {30'h0, devsel_n, trdy_n}, 32'h0);
  endtask

  task automatic finish_check();
    irdy_n = 1'b1; frame_n = 1'b1;
    chk(devsel_n === 1'b1 && trdy_n === 1'b1 && ad_oe === 1'b0, "R8 release after last",
        {29'h0, devsel_n, trdy_n, ad_oe}, 32'h6);
  endtask

  task automatic wr_phase(input logic [31:0] data, input logic [3:0] be_n, input bit last);
    ad_in = data; cbe_n = be_n; irdy_n = 1'b0; frame_n = last;
    @(posedge clk); @(negedge clk);
    if (last) finish_check();
  endtask

  task automatic rd_phase(input logic [31:0] exp, input logic [3:0] be_n, input bit last, input string req);
    cbe_n = be_n; irdy_n = 1'b0; frame_n = last; ad_in = '0;
    #1;
    chk(ad_oe === 1'b1, "R3 AD driven in read phase", {31'h0, ad_oe}, 32'h1);
    chk(ad_out === exp, req, ad_out, exp);
    @(posedge clk); @(negedge clk);
    if (last) finish_check();
  endtask

  task automatic wait_state();
    irdy_n = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write1(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be_n);
    start(4'hB, a); wr_phase(d, be_n, 1'b1);
  endtask

  task automatic read1(input logic [7:0] a, input logic [31:0] exp, input string req);
    start(4'hA, a); rd_phase(exp, 4'h0, 1'b1, req);
  endtask

  task automatic t_reset();
    chk(devsel_n === 1'b1 && trdy_n === 1'b1 && stop_n === 1'b1 && ad_oe === 1'b0,
        "R10 reset outputs", {28'h0, devsel_n, trdy_n, stop_n, ad_oe}, 32'hE);
    read1(8'h30, 32'h0, "R10 writable dword zero after reset");
  endtask

  task automatic t_lanes();
    write1(8'h10, 32'hAABBCCDD, 4'h0);
    read1(8'h10, 32'hAABBCCDD, "R4 full write");
    write1(8'h10, 32'h11223344, 4'b1010);
    read1(8'h10, 32'hAA22CC44, "R4 lanes 0 and 2 only");
  endtask

  task automatic t_burst_zero_be();
    start(4'hB, 8'h20);
    wr_phase(32'h00000001, 4'h0, 1'b0);
    wr_phase(32'h00000002, 4'hF, 1'b0);
    wait_state();
    wr_phase(32'h00000003, 4'h0, 1'b1);
    start(4'hA, 8'h20);
    rd_phase(32'h00000001, 4'hF, 1'b0, "R3 full dword with no enables");
    wait_state();
    rd_phase(32'h00000000, 4'h7, 1'b0, "R5 skipped phase wrote nothing");
    rd_phase(32'h00000003, 4'hE, 1'b1, "R6 pointer advanced past skipped phase");
  endtask

  task automatic t_readonly();
    write1(8'h00, 32'hFFFFFFFF, 4'h0);
    write1(8'h08, 32'hFFFFFFFF, 4'h0);
    read1(8'h00, 32'h3C4D1A2B, "R7 ID dword fixed");
    read1(8'h08, 32'h07800001, "R7 class dword fixed");
  endtask

  task automatic t_ignored(input bit sel, input logic [3:0] cmd, input logic [7:0] a, input string req);
    @(negedge clk);
    frame_n = 1'b0; idsel = sel; cbe_n = cmd; ad_in = {24'h0, a};
    @(negedge clk);
    idsel = 1'b0; cbe_n = 4'h0; ad_in = 32'h5A5A5A5A; irdy_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(devsel_n === 1'b1, req, {31'h0, devsel_n}, 32'h1);
    end
    frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_disconnect();
    start(4'hA, 8'hFC);
    #1;
    chk(stop_n === 1'b0 && trdy_n === 1'b0, "R9 stop with trdy at last dword",
        {30'h0, stop_n, trdy_n}, 32'h0);
    rd_phase(32'h0, 4'h0, 1'b0, "R9 last dword data");
    chk(trdy_n === 1'b1 && stop_n === 1'b0 && devsel_n === 1'b0, "R9 hold stop until frame high",
        {29'h0, trdy_n, stop_n, devsel_n}, 32'h4);
    frame_n = 1'b1;
    @(negedge clk);
    irdy_n = 1'b1;
    chk(stop_n === 1'b1 && devsel_n === 1'b1, "R9 idle after frame high",
        {30'h0, stop_n, devsel_n}, 32'h3);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lanes();
    t_burst_zero_be();
    t_readonly();
    t_ignored(1'b1, 4'hB, 8'h11, "R1 type-1 encoding ignored");
    t_ignored(1'b0, 4'hB, 8'h10, "R1 no IDSEL ignored");
    t_ignored(1'b1, 4'h6, 8'h10, "R1 other command ignored");
    read1(8'h10, 32'hAA22CC44, "R1 ignored writes left dword unchanged");
    t_disconnect();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule